// File: doc/BRIEF.md
# Banked Expansion Memory Decoder

This block is the glue logic of a peripheral card that sits on an 8-bit bus with three active-low select strobes: one for the card's device registers, one for its 256-byte slot ROM page, and one for a 2 KB expansion window that all cards share. It turns these strobes, the 11 low bus address bits and the read/write line into everything a 512Kx8 SRAM or flash part needs. That covers a 19-bit memory address, a chip select, separate output and write enables, and an enable and direction for the card's data bus buffer.

A write to the first device register stores an 8-bit bank number. Expansion-window accesses then reach bank `bank` of the part, with the bank forming address bits 18:11. Slot ROM accesses always land in the first 256 bytes of bank zero. The shared window belongs to the card only after the card's slot ROM page has been touched. Any access to the last window address hands the window back, and that address never reaches memory. Smaller parts can be used by setting how many bank bits are meaningful. The unused upper bits are held at zero, so the banks wrap.

Top module: `bankDecoder`

## Requirements
- R1: With all three selects high, memCsN, memOeN, memWeN and bufEnN are all high.
- R2: At a rising clock edge with devSelN low, rdWr low (write) and addr[3:0] equal to 0, the bank register takes dataIn. A read there, or a write at any other register offset, leaves the bank unchanged.
- R3: During an enabled window access, memAddr equals {bank, addr[10:0]}.
- R4: While slotSelN is low, memAddr equals {11'b0, addr[7:0]}, whatever the bank holds.
- R5: When winStrbN is low and addr equals 11'h7FF, there is no chip select, and at that clock edge the window enable clears.
- R6: For a memory access, memOeN is low exactly when rdWr is high (read) and memWeN is low exactly when rdWr is low (write). The two are never low together.
- R7: bufEnN is low for any memory access and for any devSelN access at register offset 0. bufDirRead always equals rdWr.
- R8: Reset clears the window enable, and any slotSelN access sets it at the clock edge. winStrbN selects memory only while the window enable is set.
- R9: Bank bits at positions BANK_USED_W and above are driven as zero in memAddr, so a smaller part sees wrapped banks.
- R10: memCsN is low for every slot ROM access and for every enabled window access other than the release address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devSelN | input | 1 | Device-register select, active low |
| slotSelN | input | 1 | Slot ROM page select, active low |
| winStrbN | input | 1 | Shared expansion-window strobe, active low |
| rdWr | input | 1 | 1 = read, 0 = write |
| addr | input | WIN_AW (11) | Bus address bits 10:0 |
| dataIn | input | 8 | Bus data, used for the bank number |
| memAddr | output | MEM_AW (19) | Memory address |
| memCsN | output | 1 | Memory chip select, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| bufEnN | output | 1 | Data bus buffer enable, active low |
| bufDirRead | output | 1 | Buffer direction, 1 drives toward the bus |

## Verification
The block holds only two pieces of state, the bank register and the window enable, and both become visible on the next access that uses them. A bank register that is wrong, or that was loaded by a stray write, shows up as wrong memAddr bits 18:11 on the first window access after the faulty edge. A window enable stuck in the wrong state shows up as a chip select that is present or missing on the next window strobe. For that reason the bench follows every load, release and re-enable with a window access in the very next cycle.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;
  typedef struct packed {
    logic loadBank;
    logic slotAcc;
    logic winAcc;
    logic regAcc;
  } ctrlStrb_t;
endpackage

// File: rtl/bankdec_ctrl.sv
module bankdec_ctrl
  import bankdec_pkg::*;
#(
  parameter int WIN_AW    = 11,
  parameter int REG_OFF_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              devSelN,
  input  logic              slotSelN,
  input  logic              winStrbN,
  input  logic              rdWr,
  input  logic [WIN_AW-1:0] addr,
  output ctrlStrb_t         strb
);
  logic winEn;
  logic lastAddr;
  logic winHit;
  logic releaseHit;

  // The slot page takes priority, so a window strobe only counts when the slot select is idle.
  assign lastAddr   = &addr;
  assign winHit     = !winStrbN && slotSelN;
  assign releaseHit = winHit && lastAddr;

  always_comb begin
    strb          = '0;
    strb.slotAcc  = !slotSelN;
    strb.winAcc   = winHit && winEn && !lastAddr;
    strb.regAcc   = !devSelN && (addr[REG_OFF_W-1:0] == '0);
    strb.loadBank = strb.regAcc && !rdWr;
  end

  // The release clears the window, and a slot page touch claims it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           winEn <= 1'b0;
    else if (releaseHit) winEn <= 1'b0;
    else if (!slotSelN)  winEn <= 1'b1;
  end
endmodule

// File: rtl/bankdec_dp.sv
module bankdec_dp
  import bankdec_pkg::*;
#(
  parameter int MEM_AW      = 19,
  parameter int WIN_AW      = 11,
  parameter int ROM_AW      = 8,
  parameter int BANK_USED_W = 8,
  localparam int BANK_W     = MEM_AW - WIN_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdWr,
  input  logic [WIN_AW-1:0] addr,
  input  logic [BANK_W-1:0] dataIn,
  input  ctrlStrb_t         strb,
  output logic [MEM_AW-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              bufEnN,
  output logic              bufDirRead
);
  logic [BANK_W-1:0] bankReg;
  logic [BANK_W-1:0] bankEff;
  logic              memAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bankReg <= '0;
    else if (strb.loadBank) bankReg <= dataIn;
  end

  // Bank bits the fitted part does not decode are tied low, so its banks wrap.
  for (genvar i = 0; i < BANK_W; i++) begin : g_bankBit
    if (i < BANK_USED_W) begin : g_keep
      assign bankEff[i] = bankReg[i];
    end else begin : g_zero
      assign bankEff[i] = 1'b0;
    end
  end

  always_comb begin
    if (strb.slotAcc)
      memAddr = {{(MEM_AW-ROM_AW){1'b0}}, addr[ROM_AW-1:0]};
    else
      memAddr = {bankEff, addr};
  end

  assign memAcc     = strb.slotAcc || strb.winAcc;
  assign memCsN     = !memAcc;
  assign memOeN     = !(memAcc && rdWr);
  assign memWeN     = !(memAcc && !rdWr);
  assign bufEnN     = !(memAcc || strb.regAcc);
  assign bufDirRead = rdWr;
endmodule

// File: rtl/bankDecoder.sv
module bankDecoder
  import bankdec_pkg::*;
#(
  parameter int MEM_AW      = 19,
  parameter int WIN_AW      = 11,
  parameter int ROM_AW      = 8,
  parameter int REG_OFF_W   = 4,
  parameter int BANK_USED_W = 8,
  localparam int BANK_W     = MEM_AW - WIN_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              devSelN,
  input  logic              slotSelN,
  input  logic              winStrbN,
  input  logic              rdWr,
  input  logic [WIN_AW-1:0] addr,
  input  logic [BANK_W-1:0] dataIn,
  output logic [MEM_AW-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              bufEnN,
  output logic              bufDirRead
);
  ctrlStrb_t strb;

  bankdec_ctrl #(.WIN_AW(WIN_AW), .REG_OFF_W(REG_OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .devSelN(devSelN), .slotSelN(slotSelN),
    .winStrbN(winStrbN), .rdWr(rdWr), .addr(addr), .strb(strb)
  );

  bankdec_dp #(.MEM_AW(MEM_AW), .WIN_AW(WIN_AW), .ROM_AW(ROM_AW),
               .BANK_USED_W(BANK_USED_W)) u_dp (
    .clk(clk), .rstN(rstN), .rdWr(rdWr), .addr(addr), .dataIn(dataIn),
    .strb(strb), .memAddr(memAddr), .memCsN(memCsN), .memOeN(memOeN),
    .memWeN(memWeN), .bufEnN(bufEnN), .bufDirRead(bufDirRead)
  );
endmodule

// File: rtl/bankdec_chk.sv
module bankdec_chk #(
  parameter int MEM_AW      = 19,
  parameter int WIN_AW      = 11,
  parameter int ROM_AW      = 8,
  parameter int REG_OFF_W   = 4,
  parameter int BANK_USED_W = 8,
  localparam int BANK_W     = MEM_AW - WIN_AW
) (
  input logic              clk,
  input logic              rstN,
  input logic              devSelN,
  input logic              slotSelN,
  input logic              winStrbN,
  input logic              rdWr,
  input logic [WIN_AW-1:0] addr,
  input logic [BANK_W-1:0] dataIn,
  input logic [MEM_AW-1:0] memAddr,
  input logic              memCsN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              bufEnN,
  input logic              bufDirRead
);
  localparam logic [BANK_W-1:0] KEEP = BANK_W'((1 << BANK_USED_W) - 1);

  logic loadCond;
  logic relCond;
  assign loadCond = !devSelN && !rdWr && (addr[REG_OFF_W-1:0] == '0);
  assign relCond  = !winStrbN && slotSelN && (&addr);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (devSelN && slotSelN && winStrbN) |-> (memCsN && memOeN && memWeN && bufEnN));

  a_r2_bank_loaded: assert property (@(posedge clk) disable iff (!rstN)
    ($past(loadCond) && !memCsN && slotSelN) |->
      (memAddr[MEM_AW-1:WIN_AW] == ($past(dataIn) & KEEP)));

  a_r4_slot_bank_zero: assert property (@(posedge clk) disable iff (!rstN)
    !slotSelN |-> (memAddr[MEM_AW-1:ROM_AW] == '0));

  a_r5_release_no_cs: assert property (@(posedge clk) disable iff (!rstN)
    relCond |-> memCsN);

  a_r5_release_sticks: assert property (@(posedge clk) disable iff (!rstN)
    ($past(relCond) && slotSelN) |-> memCsN);

  a_r6_enables_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  a_r6_we_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCsN && !rdWr));

  a_r7_dir_follows: assert property (@(posedge clk) disable iff (!rstN)
    bufDirRead == rdWr);

  a_r10_slot_selects: assert property (@(posedge clk) disable iff (!rstN)
    !slotSelN |-> (!memCsN && !bufEnN));
endmodule

bind bankDecoder bankdec_chk #(
  .MEM_AW(MEM_AW), .WIN_AW(WIN_AW), .ROM_AW(ROM_AW),
  .REG_OFF_W(REG_OFF_W), .BANK_USED_W(BANK_USED_W)
) u_chk (.*);

// File: tb/bankDecoder_tb.sv
`timescale 1ns/1ps
module bankDecoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        devSelN = 1'b1, slotSelN = 1'b1, winStrbN = 1'b1, rdWr = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [18:0] memAddr, memAddrS;
  logic        memCsN, memOeN, memWeN, bufEnN, bufDirRead;
  logic        csS, oeS, weS, bufS, dirS;
  int          nChk = 0, nErr = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  bankDecoder u_dut (.clk(clk), .rstN(rstN), .devSelN(devSelN), .slotSelN(slotSelN),
    .winStrbN(winStrbN), .rdWr(rdWr), .addr(addr), .dataIn(dataIn), .memAddr(memAddr),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .bufEnN(bufEnN),
    .bufDirRead(bufDirRead));

  bankDecoder #(.BANK_USED_W(6)) u_dutSmall (.clk(clk), .rstN(rstN), .devSelN(devSelN),
    .slotSelN(slotSelN), .winStrbN(winStrbN), .rdWr(rdWr), .addr(addr), .dataIn(dataIn),
    .memAddr(memAddrS), .memCsN(csS), .memOeN(oeS), .memWeN(weS), .bufEnN(bufS),
    .bufDirRead(dirS));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at the falling edge and let the combinational outputs settle.
  task automatic bus(input logic d, input logic s, input logic w, input logic rw,
                     input logic [10:0] a, input logic [7:0] dt);
    @(negedge clk);
    devSelN = d; slotSelN = s; winStrbN = w; rdWr = rw; addr = a; dataIn = dt;
    #2;
  endtask

  task automatic idle();
    bus(1, 1, 1, 1, 11'h0, 8'h0);
  endtask

  task automatic t_reset();
    idle();
    chk("R1 cs", memCsN, 1); chk("R1 oe", memOeN, 1);
    chk("R1 we", memWeN, 1); chk("R1 buf", bufEnN, 1);
    bus(1, 1, 0, 1, 11'h100, 0);
    chk("R8 window off after reset", memCsN, 1);
    chk("R7 no buffer without access", bufEnN, 1);
    idle();
  endtask

  task automatic t_slotRead();
    bus(1, 0, 1, 1, 11'h3A5, 0);
    chk("R4 slot address", memAddr, 19'h000A5);
    chk("R10 slot cs", memCsN, 0);
    chk("R6 read oe", memOeN, 0); chk("R6 read we", memWeN, 1);
    chk("R7 buf on", bufEnN, 0); chk("R7 dir read", bufDirRead, 1);
    idle();
  endtask

  task automatic t_windowRead();
    bus(1, 1, 0, 1, 11'h234, 0);
    chk("R8 window claimed by slot", memCsN, 0);
    chk("R3 bank zero window address", memAddr, 19'h00234);
    idle();
  endtask

  task automatic t_bankLoad();
    bus(0, 1, 1, 0, 11'h000, 8'h5C);
    chk("R7 buf on reg write", bufEnN, 0);
    chk("R7 dir write", bufDirRead, 0);
    chk("R2 reg access not memory", memCsN, 1);
    bus(1, 1, 0, 1, 11'h6F1, 0);
    chk("R2 R3 loaded bank", memAddr, 19'h2E6F1);
    bus(0, 1, 1, 1, 11'h000, 8'h11);
    bus(0, 1, 1, 0, 11'h003, 8'h22);
    chk("R7 no buf other offset", bufEnN, 1);
    bus(1, 1, 0, 1, 11'h6F1, 0);
    chk("R2 bank unchanged", memAddr, 19'h2E6F1);
    idle();
  endtask

  task automatic t_windowWrite();
    bus(1, 1, 0, 0, 11'h010, 0);
    chk("R6 write we", memWeN, 0); chk("R6 write oe", memOeN, 1);
    chk("R10 window cs", memCsN, 0);
    chk("R3 write address", memAddr, 19'h2E010);
    idle();
  endtask

  task automatic t_slotForce();
    bus(1, 0, 1, 1, 11'h0FF, 0);
    chk("R4 slot forces bank 0", memAddr, 19'h000FF);
    idle();
  endtask

  task automatic t_release();
    bus(1, 1, 0, 1, 11'h7FF, 0);
    chk("R5 release cs", memCsN, 1); chk("R5 release oe", memOeN, 1);
    chk("R5 release buf", bufEnN, 1);
    bus(1, 1, 0, 1, 11'h010, 0);
    chk("R5 window dropped", memCsN, 1);
    bus(1, 0, 1, 1, 11'h001, 0);
    bus(1, 1, 0, 1, 11'h010, 0);
    chk("R8 reclaimed", memCsN, 0);
    chk("R3 after reclaim", memAddr, 19'h2E010);
    idle();
  endtask

  task automatic t_wrap();
    bus(0, 1, 1, 0, 11'h000, 8'hFF);
    bus(1, 1, 0, 1, 11'h001, 0);
    chk("R9 full part", memAddr, 19'h7F801);
    chk("R9 small part wraps", memAddrS, 19'h1F801);
    chk("R10 small cs", csS, 0);
    idle();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nErr++; nChk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_slotRead();
    t_windowRead();
    t_bankLoad();
    t_windowWrite();
    t_slotForce();
    t_release();
    t_wrap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule